// File: doc/BRIEF.md
# Command-Driven Random Word Generator

This block is a register-mapped random number front end. Software writes a short operation code into a command register to start a random-data run or a reseed. It polls or takes an interrupt on a write-1-to-clear status flag, then reads up to eight 32-bit result words. A deterministic 32-bit shift-register generator stands in for a physical entropy source, so every output is predictable from the seed. This lets the block be used for bring-up and regression of the software that drives a real random source.

Each operation takes a fixed number of clock cycles, set by a parameter. Writing the no-operation code while a run is in progress cancels it cleanly. A programmable limit counts generated 16-byte blocks and remixes the generator state by itself when the limit is reached. A constant identification code can be read back. After reset the block runs one short generation on its own, so the ready flag can come up before software has issued any command.

Top module: `rng_cmd_top`

## Requirements
- R1: After synchronous reset, the mode, interrupt-enable and reseed-limit registers read 0 and irq is 0. The block starts one 128-bit generation from the initial seed by itself, so the command register reads 1 and status bit 0 later becomes 1 with no command issued.
- R2: The command field is bits [1:0] at offset 0x00, with 0 = no operation, 1 = generate and 2 = reseed. Code 3 is ignored. A read returns the code of the operation in progress, or 0 when idle. A generate or reseed code written while an operation is in progress is ignored.
- R3: An operation accepted at a clock edge completes exactly OP_CYCLES edges later. At that edge a generate sets status bit 0 and a reseed sets status bit 1. A read sampled at the edge after completion sees the flag.
- R4: The status register at offset 0x14 is write-1-to-clear: a 1 written to a bit clears it, and a 0 leaves it unchanged.
- R5: Bit 3 of the mode register at offset 0x08 selects the output width, with 0 = 128 bits and 1 = 256 bits. The width used is the value held when the generate command is accepted. In 128-bit mode, words 0 to 3 are refreshed and words 4 to 7 are set to zero.
- R6: The generator state is 32 bits wide and starts at 0x1ACEB00C. One step maps s to (s >> 1) XOR (s[0] ? 0x80200003 : 0). Result word k, at offset 0x20 + 4k, is the state stepped k+1 times. After a run, the state is the value stepped 4 times (128-bit) or 8 times (256-bit).
- R7: The remix function is m(s) = {s[15:0], s[31:16]} XOR 0x6D2B79F5, with 0x6D2B79F5 used if the result is zero. A reseed replaces the state with m(state), leaves the result words unchanged and clears the block counter.
- R8: The reseed-limit register at offset 0x60 holds N, the low 16 bits of the written value. Each completed generate adds 1 (128-bit) or 2 (256-bit) to a block counter. If N is not 0 and the counter reaches N or more, the post-run state is replaced by m(state) and the counter restarts at 0. Seed-done is not set. N = 0 disables this.
- R9: Writing code 0 while an operation is in progress aborts it. No status bit is set, the result words and generator state are unchanged, and the command register reads 0.
- R10: The interrupt-enable register at offset 0x10 stores bit 31 (global), bit 1 (seed-done) and bit 0 (ready); other bits read 0. irq is registered and equals the global bit AND ((status0 AND enable0) OR (status1 AND enable1)) of the previous cycle.
- R11: Reads have one cycle of latency. Offset 0xF0 always reads 0x000046BC and ignores writes. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench measures the exact cycle at which the ready flag appears after a command. A sequencer off by one edge would make the ready flag appear one read early or one read late.

It issues aborts at random points inside a run, including near the end. A design that lets completion win over the abort would raise a flag or change the words.

It changes the mode register and writes a second command while a run is in progress. A design that does not latch the width, or that queues the extra command, would return the wrong number of words or set seed-done.

The auto-reseed counter is driven across its limit with mixed 128-bit and 256-bit runs. The power-on run also counts toward the limit. Miscounting the blocks shifts every later word away from the bench's model.

// File: rtl/rng_cmd_pkg.sv
package rng_cmd_pkg;

  localparam logic [1:0] OP_NOP  = 2'd0;
  localparam logic [1:0] OP_RAND = 2'd1;
  localparam logic [1:0] OP_SEED = 2'd2;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h08;
  localparam logic [7:0] OFS_IE   = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_RES  = 8'h20;
  localparam logic [7:0] OFS_RQ   = 8'h60;
  localparam logic [7:0] OFS_VER  = 8'hF0;

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;
  localparam logic [31:0] MIX_KEY   = 32'h6D2B_79F5;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_TAPS : 32'h0);
  endfunction

  function automatic logic [31:0] mix_seed(input logic [31:0] s);
    logic [31:0] y;
    y = {s[15:0], s[31:16]} ^ MIX_KEY;
    return (y == 32'h0) ? MIX_KEY : y;
  endfunction

endpackage

// File: rtl/rng_cmd_seq.sv
module rng_cmd_seq
  import rng_cmd_pkg::*;
#(
  parameter int OP_CYCLES = 16,
  parameter int RQ_W      = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_we,
  input  logic [1:0]      cmd_op,
  input  logic            mode_wide,
  input  logic [RQ_W-1:0] rq_limit,
  output logic            busy,
  output logic [1:0]      op_now,
  output logic            wide_q,
  output logic            rand_fin,
  output logic            seed_fin,
  output logic            reseed_auto
);

  localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [RQ_W:0]    blk_q;
  logic [RQ_W:0]    blk_sum;
  logic             abort;
  logic             fin;
  logic             start;

  // an abort on the completion edge wins over completion
  assign abort    = busy && cmd_we && (cmd_op == OP_NOP);
  assign fin      = busy && (cnt_q == '0) && !abort;
  assign start    = !busy && cmd_we && ((cmd_op == OP_RAND) || (cmd_op == OP_SEED));
  assign rand_fin = fin && (op_now == OP_RAND);
  assign seed_fin = fin && (op_now == OP_SEED);

  // 16-byte blocks produced by the finishing run: 1 narrow, 2 wide
  assign blk_sum     = blk_q + {{(RQ_W-1){1'b0}}, wide_q, ~wide_q};
  assign reseed_auto = rand_fin && (rq_limit != '0) && (blk_sum >= {1'b0, rq_limit});

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b1;
      op_now <= OP_RAND;
      cnt_q  <= CNT_LOAD;
      wide_q <= 1'b0;
      blk_q  <= '0;
    end else begin
      if (busy) begin
        if (abort || fin) begin
          busy   <= 1'b0;
          op_now <= OP_NOP;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start) begin
        busy   <= 1'b1;
        op_now <= cmd_op;
        cnt_q  <= CNT_LOAD;
        wide_q <= mode_wide;
      end

      if (seed_fin || reseed_auto) begin
        blk_q <= '0;
      end else if (rand_fin) begin
        blk_q <= blk_sum;
      end
    end
  end

endmodule

// File: rtl/rng_cmd_gen.sv
module rng_cmd_gen
  import rng_cmd_pkg::*;
#(
  parameter int          N_WORDS   = 8,
  parameter logic [31:0] SEED_INIT = 32'h1ACE_B00C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rand_fin,
  input  logic                 narrow,
  input  logic                 seed_fin,
  input  logic                 reseed_auto,
  output logic [N_WORDS*32-1:0] words
);

  localparam int HALF = N_WORDS / 2;

  logic [31:0] state_q;
  logic [31:0] chain [N_WORDS+1];
  logic [31:0] post_run;

  assign chain[0] = state_q;

  for (genvar k = 0; k < N_WORDS; k++) begin : g_step
    assign chain[k+1]          = lfsr_next(chain[k]);
    assign words[k*32 +: 32]   = chain[k+1];
  end

  assign post_run = narrow ? chain[HALF] : chain[N_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED_INIT;
    end else if (rand_fin) begin
      state_q <= reseed_auto ? mix_seed(post_run) : post_run;
    end else if (seed_fin) begin
      state_q <= mix_seed(state_q);
    end
  end

endmodule

// File: rtl/rng_cmd_top.sv
module rng_cmd_top
  import rng_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          N_WORDS   = 8,
  parameter int          OP_CYCLES = 16,
  parameter int          RQ_W      = 16,
  parameter logic [31:0] SEED_INIT = 32'h1ACE_B00C,
  parameter logic [15:0] VERSION   = 16'h46BC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);

  localparam int HALF  = N_WORDS / 2;
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [ADDR_W-1:0] RES_SPAN = ADDR_W'(4 * N_WORDS);

  logic              mode_wide_q;
  logic              ie_glb_q;
  logic [1:0]        ie_src_q;
  logic [1:0]        stat_q;
  logic [RQ_W-1:0]   rq_q;
  logic [31:0]       res_q [N_WORDS];

  logic              busy;
  logic [1:0]        op_now;
  logic              wide_q;
  logic              rand_fin;
  logic              seed_fin;
  logic              reseed_auto;
  logic [N_WORDS*32-1:0] gen_words;

  logic hit_cmd, hit_mode, hit_ie, hit_stat, hit_rq, hit_ver, hit_res;
  logic [ADDR_W-1:0] res_off;
  logic [IDX_W-1:0]  res_idx;
  logic [31:0]       rd_val;

  // address decode
  assign hit_cmd  = (addr == ADDR_W'(OFS_CMD));
  assign hit_mode = (addr == ADDR_W'(OFS_MODE));
  assign hit_ie   = (addr == ADDR_W'(OFS_IE));
  assign hit_stat = (addr == ADDR_W'(OFS_STAT));
  assign hit_rq   = (addr == ADDR_W'(OFS_RQ));
  assign hit_ver  = (addr == ADDR_W'(OFS_VER));
  assign res_off  = addr - ADDR_W'(OFS_RES);
  assign hit_res  = (addr >= ADDR_W'(OFS_RES)) && (res_off < RES_SPAN) && (addr[1:0] == 2'b00);
  assign res_idx  = res_off[IDX_W+1:2];

  rng_cmd_seq #(
    .OP_CYCLES (OP_CYCLES),
    .RQ_W      (RQ_W)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_we      (wr_en && hit_cmd),
    .cmd_op      (wdata[1:0]),
    .mode_wide   (mode_wide_q),
    .rq_limit    (rq_q),
    .busy        (busy),
    .op_now      (op_now),
    .wide_q      (wide_q),
    .rand_fin    (rand_fin),
    .seed_fin    (seed_fin),
    .reseed_auto (reseed_auto)
  );

  rng_cmd_gen #(
    .N_WORDS   (N_WORDS),
    .SEED_INIT (SEED_INIT)
  ) gen_i (
    .clk         (clk),
    .rst         (rst),
    .rand_fin    (rand_fin),
    .narrow      (~wide_q),
    .seed_fin    (seed_fin),
    .reseed_auto (reseed_auto),
    .words       (gen_words)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_wide_q <= 1'b0;
      ie_glb_q    <= 1'b0;
      ie_src_q    <= 2'b00;
      rq_q        <= '0;
    end else if (wr_en) begin
      if (hit_mode) mode_wide_q <= wdata[3];
      if (hit_ie) begin
        ie_glb_q <= wdata[31];
        ie_src_q <= wdata[1:0];
      end
      if (hit_rq) rq_q <= wdata[RQ_W-1:0];
    end
  end

  // status flags: set by completion, cleared by writing 1
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 2'b00;
    end else begin
      stat_q[0] <= rand_fin | (stat_q[0] & ~(wr_en & hit_stat & wdata[0]));
      stat_q[1] <= seed_fin | (stat_q[1] & ~(wr_en & hit_stat & wdata[1]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= ie_glb_q & |(stat_q & ie_src_q);
    end
  end

  // result words; upper half is zeroed by a narrow run
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_WORDS; k++) res_q[k] <= '0;
    end else if (rand_fin) begin
      for (int k = 0; k < N_WORDS; k++) begin
        if ((k < HALF) || wide_q) res_q[k] <= gen_words[k*32 +: 32];
        else                      res_q[k] <= '0;
      end
    end
  end

  // read path
  always_comb begin
    rd_val = 32'h0;
    if (hit_cmd)       rd_val = {30'h0, op_now};
    else if (hit_mode) rd_val = {28'h0, mode_wide_q, 3'b000};
    else if (hit_ie)   rd_val = {ie_glb_q, 29'h0, ie_src_q};
    else if (hit_stat) rd_val = {30'h0, stat_q};
    else if (hit_rq)   rd_val = 32'(rq_q);
    else if (hit_ver)  rd_val = 32'(VERSION);
    else if (hit_res)  rd_val = res_q[res_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 32'h0;
    end else if (rd_en) begin
      rdata <= rd_val;
    end
  end

endmodule

// File: rtl/rng_cmd_chk.sv
module rng_cmd_chk
  import rng_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          OP_CYCLES = 16,
  parameter logic [15:0] VERSION   = 16'h46BC
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              irq,
  input logic              busy,
  input logic [1:0]        stat_q,
  input logic              ie_glb_q,
  input logic              rand_fin
);

  int run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 0;
    else     run_q <= busy ? run_q + 1 : 0;
  end

  assert_busy_window_R3: assert property (@(posedge clk) disable iff (rst)
    run_q <= OP_CYCLES);

  assert_ready_after_run_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[0]) |-> $past(busy));

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_STAT) && wdata[0] && !rand_fin) |=> !stat_q[0]);

  assert_abort_no_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && addr == ADDR_W'(OFS_CMD) && wdata[1:0] == OP_NOP) |=> $stable(stat_q));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(ie_glb_q) |-> !irq);

  assert_version_const_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFS_VER)) |=> (rdata == 32'(VERSION)));

endmodule

bind rng_cmd_top rng_cmd_chk #(
  .ADDR_W    (ADDR_W),
  .OP_CYCLES (OP_CYCLES),
  .VERSION   (VERSION)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq      (irq),
  .busy     (busy),
  .stat_q   (stat_q),
  .ie_glb_q (ie_glb_q),
  .rand_fin (rand_fin)
);

// File: tb/rng_cmd_top_tb_top.sv
`timescale 1ns/1ps
module rng_cmd_top_tb_top;

  localparam int OPC = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_state;
  logic [31:0] m_res [8];
  int          m_blk;
  int          m_lim;

  always #4 clk = ~clk;

  rng_cmd_top dut_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  function automatic logic [31:0] f_step(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic logic [31:0] f_mix(input logic [31:0] s);
    logic [31:0] y;
    y = {s[15:0], s[31:16]} ^ 32'h6D2B_79F5;
    if (y == 32'h0) y = 32'h6D2B_79F5;
    return y;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks are entered at a falling edge and return at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    int guard;
    guard = 0;
    rd(8'h00, v);
    while (v != 32'h0 && guard < 200) begin
      rd(8'h00, v);
      guard++;
    end
    if (guard >= 200) chk({tag, " operation never finished"}, v, 32'h0);
  endtask

  task automatic model_rand(input bit wide);
    logic [31:0] s;
    int n;
    s = m_state;
    n = wide ? 8 : 4;
    for (int k = 0; k < 8; k++) begin
      if (k < n) begin
        s = f_step(s);
        m_res[k] = s;
      end else begin
        m_res[k] = 32'h0;
      end
    end
    m_blk += wide ? 2 : 1;
    if (m_lim != 0 && m_blk >= m_lim) begin
      s = f_mix(s);
      m_blk = 0;
    end
    m_state = s;
  endtask

  task automatic check_words(input string tag);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      rd(8'h20 + 8'(4 * k), v);
      chk(tag, v, m_res[k]);
    end
  endtask

  task automatic run_rand(input bit wide, input bit clear, input string tag);
    logic [31:0] v;
    wr(8'h08, wide ? 32'h8 : 32'h0);
    wr(8'h00, 32'h1);
    wait_idle(tag);
    model_rand(wide);
    rd(8'h14, v);
    chk({tag, " ready flag"}, v, 32'h1);
    check_words(tag);
    if (clear) wr(8'h14, 32'h3);
  endtask

  task automatic run_seed(input string tag);
    logic [31:0] v;
    wr(8'h00, 32'h2);
    wait_idle(tag);
    m_state = f_mix(m_state);
    m_blk = 0;
    rd(8'h14, v);
    chk({tag, " seed-done flag"}, v, 32'h2);
    check_words({tag, " words kept"});
    wr(8'h14, 32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt;
    void'($urandom(32'h0000_5EED));
    m_state = 32'h1ACE_B00C;
    m_blk = 0;
    m_lim = 0;
    for (int k = 0; k < 8; k++) m_res[k] = 32'h0;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, power-on generation in progress
    rd(8'h00, v); chk("R1 cmd busy after reset", v, 32'h1);
    rd(8'h08, v); chk("R1 mode reset", v, 32'h0);
    rd(8'h10, v); chk("R1 irq enable reset", v, 32'h0);
    rd(8'h60, v); chk("R1 reseed limit reset", v, 32'h0);
    chk("R1 irq reset", {31'h0, irq}, 32'h0);
    rd(8'hF0, v); chk("R11 version", v, 32'h0000_46BC);
    rd(8'h44, v); chk("R11 unmapped read", v, 32'h0);
    wr(8'hF0, 32'h1234_5678);
    rd(8'hF0, v); chk("R11 version ignores write", v, 32'h0000_46BC);
    wait_idle("R1 power-on");
    rd(8'h14, v); chk("R1 ready without command", v, 32'h1);
    model_rand(1'b0);
    check_words("R6 power-on words");

    // R4 write-1-to-clear
    wr(8'h14, 32'h0); rd(8'h14, v); chk("R4 write 0 keeps flag", v, 32'h1);
    wr(8'h14, 32'h2); rd(8'h14, v); chk("R4 other bit keeps flag", v, 32'h1);
    wr(8'h14, 32'h1); rd(8'h14, v); chk("R4 write 1 clears", v, 32'h0);

    // R3 exact latency
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R2 cmd reads op in progress", v, 32'h1);
    cnt = 1;
    v = 32'h0;
    while (v[0] == 1'b0 && cnt < 100) begin
      rd(8'h14, v);
      cnt++;
    end
    chk("R3 reads until ready", 32'(cnt), 32'(OPC + 1));
    model_rand(1'b0);
    check_words("R6 narrow words");
    wr(8'h14, 32'h1);

    // R5 mode latched at command acceptance
    wr(8'h08, 32'h8);
    wr(8'h00, 32'h1);
    wr(8'h08, 32'h0);
    wait_idle("R5 latch");
    model_rand(1'b1);
    check_words("R5 wide mode latched");
    wr(8'h14, 32'h1);
    rd(8'h08, v); chk("R5 mode readback", v, 32'h0);
    run_rand(1'b0, 1'b1, "R5 narrow zeroes upper words");

    // R2 commands while busy and reserved code
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h1);
    wr(8'h00, 32'h2);
    wait_idle("R2 busy");
    model_rand(1'b0);
    rd(8'h14, v); chk("R2 seed during run ignored", v, 32'h1);
    check_words("R2 words after ignored seed");
    wr(8'h14, 32'h1);
    wr(8'h00, 32'h3);
    rd(8'h00, v); chk("R2 reserved code ignored", v, 32'h0);
    idle(OPC + 2);
    rd(8'h14, v); chk("R2 reserved code sets nothing", v, 32'h0);

    // R9 abort
    wr(8'h08, 32'h8);
    wr(8'h00, 32'h1);
    idle(3);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R9 abort returns to idle", v, 32'h0);
    idle(OPC + 4);
    rd(8'h14, v); chk("R9 abort sets no flag", v, 32'h0);
    check_words("R9 abort keeps words");
    run_rand(1'b1, 1'b1, "R9 state kept after abort");

    // R7 reseed
    run_seed("R7 seed");
    run_rand(1'b0, 1'b1, "R7 words after seed");

    // R8 auto reseed
    wr(8'h60, 32'h0001_0005);
    rd(8'h60, v); chk("R8 limit width", v, 32'h5);
    wr(8'h60, 32'h3);
    m_lim = 3;
    run_seed("R8 counter clear");
    run_rand(1'b1, 1'b0, "R8 two blocks");
    wr(8'h14, 32'h1);
    run_rand(1'b0, 1'b0, "R8 limit reached");
    rd(8'h14, v); chk("R8 auto reseed sets no seed-done", v, 32'h1);
    wr(8'h14, 32'h1);
    run_rand(1'b0, 1'b1, "R8 words after auto reseed");

    // R10 interrupt
    run_rand(1'b0, 1'b0, "R10 setup");
    wr(8'h10, 32'h0000_0001); idle(2);
    chk("R10 no global enable", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'h8000_0001); idle(2);
    chk("R10 ready interrupt", {31'h0, irq}, 32'h1);
    wr(8'h10, 32'h8000_0002); idle(2);
    chk("R10 seed source idle", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R10 enable readback", v, 32'h8000_0003);
    idle(1);
    chk("R10 all enabled", {31'h0, irq}, 32'h1);
    wr(8'h14, 32'h1); idle(2);
    chk("R10 cleared flag drops irq", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'h0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      op = $urandom_range(0, 4);
      case (op)
        0: run_rand(1'b0, 1'b1, "R6 random narrow");
        1: run_rand(1'b1, 1'b1, "R6 random wide");
        2: run_seed("R7 random seed");
        3: begin
          int lim;
          lim = $urandom_range(0, 4);
          wr(8'h60, 32'(lim));
          m_lim = lim;
        end
        default: begin
          int d;
          d = $urandom_range(0, OPC - 2);
          wr(8'h08, 32'h8);
          wr(8'h00, 32'h1);
          idle(d);
          wr(8'h00, 32'h0);
          idle(OPC);
          rd(8'h14, v); chk("R9 random abort flag", v, 32'h0);
          check_words("R9 random abort words");
        end
      endcase
    end
    run_rand(1'b1, 1'b1, "R8 final state");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule